// File: doc/BRIEF.md
# Dual-Issue Pairing and Pipe Allocator

This block is the in-order issue stage of a two-pipe integer core. Each cycle it looks at the two oldest decoded instructions, held in an older slot and a younger slot. It decides whether none, one or both of them issue, and it assigns each issued micro-op to ALU pipe 0, pipe 1 or both. Dependency checking is done elsewhere. Its outcome arrives here as one blocking bit per slot.

Some instructions expand into several micro-ops. Examples are long multiplies and load or store multiples of three or four registers. The block steps such an instruction through consecutive cycles with an internal micro-op counter. On every cycle except the last, the micro-op holds both pipes, so nothing pairs with it. Its last micro-op goes to pipe 0 and may pair with a younger single-micro-op instruction. Pairing is also limited by two per-cycle caps: one single-micro-op memory access and one branch. A stall input freezes the whole stage.

The upstream queue pops the older slot when `s0_retire` is high. It pops the younger slot when `s1_grant` is high.

Top module: `dual_issue_alloc`

## Requirements
- R1: While `rst_n` is low, no grant is asserted and `uop_idx` reads 0. An asynchronous reset in the middle of a sequence restarts that instruction at micro-op 0.
- R2: Issue is in order. `s1_grant` is never high unless `s0_grant` is high in the same cycle.
- R3: Pipe masks use bit 0 for pipe 0 and bit 1 for pipe 1. If both slots hold single-micro-op instructions, are valid and unblocked, and no cap is hit, both issue: the older slot gets mask 2'b01 and the younger gets 2'b10.
- R4: Class codes are 2'b00 ALU, 2'b01 memory access and 2'b10 branch. Two single-micro-op memory accesses never issue together. Only the older one issues.
- R5: Two branches never issue together. Only the older one issues.
- R6: A two-micro-op instruction issues with mask 2'b11 and index 0, and nothing pairs with it. On the next issue cycle it uses mask 2'b01 with index 1, and pairing is allowed.
- R7: A three-micro-op instruction uses mask 2'b11 for indices 0 and 1 with no pairing. It then uses mask 2'b01 for index 2, where pairing is allowed. The index advances by one on each issued micro-op that is not the last.
- R8: The memory-access cap counts only single-micro-op accesses. A multi-micro-op memory access may pair with a single memory access on its last micro-op.
- R9: While `stall` is high, no grant is asserted, and the micro-op index and any sequence in progress are held.
- R10: `s0_block` stops the older slot and therefore also the younger one. `s1_block` stops only the younger slot.
- R11: An instruction of more than one micro-op in the younger slot never issues from that slot.
- R12: `s0_retire` is high exactly when the older slot issues its final micro-op. An issued mask of zero is reported on any slot not granted.
- R13: A micro-op count of 0 is treated as 1. A count above `UOP_MAX` is treated as `UOP_MAX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Downstream stall; freezes issue |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_class | input | 2 | Older slot class code |
| s0_uops | input | UW | Older slot micro-op count |
| s0_block | input | 1 | Older slot blocked by a hazard |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_class | input | 2 | Younger slot class code |
| s1_uops | input | UW | Younger slot micro-op count |
| s1_block | input | 1 | Younger slot blocked by a hazard |
| s0_grant | output | 1 | Older slot issues a micro-op |
| s0_pipes | output | 2 | Pipe mask used by the older slot |
| s0_retire | output | 1 | Older slot issued its last micro-op |
| s1_grant | output | 1 | Younger slot issues |
| s1_pipes | output | 2 | Pipe mask used by the younger slot |
| uop_idx | output | UW | Index of the older slot's current micro-op |

## Verification
The bench builds the block with its defaults: `UOP_MAX` of 3 and both caps active (`MEM_CAP` and `BR_CAP` of 1). This width makes the full three-micro-op lock pattern reachable. With these settings the stall can also land mid-sequence, between the two locked cycles. Because both caps are active, each clash and its exception for multi-micro-op memory accesses can be observed at the grant and mask outputs.

// File: rtl/issue_pair_pkg.sv
package issue_pair_pkg;
   typedef enum logic [1:0] {
      CL_ALU    = 2'b00,
      CL_MEM    = 2'b01,
      CL_BRANCH = 2'b10,
      CL_OTHER  = 2'b11
   } iclass_e;

   localparam logic [1:0] PIPE_NONE = 2'b00;
   localparam logic [1:0] PIPE_ZERO = 2'b01;
   localparam logic [1:0] PIPE_ONE  = 2'b10;
   localparam logic [1:0] PIPE_BOTH = 2'b11;
endpackage

// File: rtl/issue_uop_seq.sv
module issue_uop_seq #(
   parameter int UOP_MAX = 3,
   parameter int UW      = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic [UW-1:0] cnt,
   output logic [UW-1:0] idx,
   output logic          last,
   output logic          lock
);
   logic [UW-1:0] idx_q;

   assign idx  = idx_q;
   assign last = (idx_q == UW'(cnt - UW'(1)));
   assign lock = !last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (fire)
         idx_q <= last ? '0 : UW'(idx_q + UW'(1));
   end

   // R7: each non-final issued micro-op moves the index up by one
   p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !last) |=> (idx_q == UW'($past(idx_q) + UW'(1))));

   // R7: the index stays inside the legal micro-op range
   p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q < UW'(UOP_MAX));

   // R12: a final micro-op restarts the counter
   p_idx_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && last) |=> (idx_q == '0));
endmodule

// File: rtl/issue_pair_rules.sv
module issue_pair_rules
   import issue_pair_pkg::*;
#(
   parameter int MEM_CAP = 1,
   parameter int BR_CAP  = 1
) (
   input  iclass_e cls0,
   input  iclass_e cls1,
   input  logic    s0_single,
   input  logic    s0_last,
   input  logic    s1_single,
   output logic    pair_ok
);
   logic mem_clash;
   logic br_clash;

   if (MEM_CAP < 1 || MEM_CAP > 2) begin : g_bad_mem
      $error("MEM_CAP must be 1 or 2");
   end
   if (BR_CAP < 1 || BR_CAP > 2) begin : g_bad_br
      $error("BR_CAP must be 1 or 2");
   end

   if (MEM_CAP == 1) begin : g_mem_cap
      assign mem_clash = (cls0 == CL_MEM) && (cls1 == CL_MEM) && s0_single;
   end else begin : g_mem_free
      assign mem_clash = 1'b0;
   end

   if (BR_CAP == 1) begin : g_br_cap
      assign br_clash = (cls0 == CL_BRANCH) && (cls1 == CL_BRANCH);
   end else begin : g_br_free
      assign br_clash = 1'b0;
   end

   assign pair_ok = s0_last && s1_single && !mem_clash && !br_clash;
endmodule

// File: rtl/issue_pipe_map.sv
module issue_pipe_map
   import issue_pair_pkg::*;
(
   input  logic       g0,
   input  logic       g1,
   input  logic       lock,
   output logic [1:0] p0,
   output logic [1:0] p1
);
   always_comb begin
      p0 = PIPE_NONE;
      p1 = PIPE_NONE;
      if (g0) p0 = lock ? PIPE_BOTH : PIPE_ZERO;
      if (g1) p1 = PIPE_ONE;
   end
endmodule

// File: rtl/dual_issue_alloc.sv
module dual_issue_alloc
   import issue_pair_pkg::*;
#(
   parameter  int UOP_MAX = 3,
   parameter  int MEM_CAP = 1,
   parameter  int BR_CAP  = 1,
   localparam int UW      = $clog2(UOP_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stall,
   input  logic          s0_valid,
   input  logic [1:0]    s0_class,
   input  logic [UW-1:0] s0_uops,
   input  logic          s0_block,
   input  logic          s1_valid,
   input  logic [1:0]    s1_class,
   input  logic [UW-1:0] s1_uops,
   input  logic          s1_block,
   output logic          s0_grant,
   output logic [1:0]    s0_pipes,
   output logic          s0_retire,
   output logic          s1_grant,
   output logic [1:0]    s1_pipes,
   output logic [UW-1:0] uop_idx
);
   if (UOP_MAX < 2) begin : g_bad_uops
      $error("UOP_MAX must be at least 2");
   end

   function automatic logic [UW-1:0] norm_cnt(input logic [UW-1:0] n);
      if (n == '0)             return UW'(1);
      if (n > UW'(UOP_MAX))    return UW'(UOP_MAX);
      return n;
   endfunction

   iclass_e       cls0, cls1;
   logic [UW-1:0] cnt0, cnt1;
   logic          seq_last, seq_lock, pair_ok;

   assign cls0 = iclass_e'(s0_class);
   assign cls1 = iclass_e'(s1_class);
   assign cnt0 = norm_cnt(s0_uops);
   assign cnt1 = norm_cnt(s1_uops);

   assign s0_grant  = rst_n && !stall && s0_valid && !s0_block;
   assign s1_grant  = s0_grant && s1_valid && !s1_block && pair_ok;
   assign s0_retire = s0_grant && seq_last;

   issue_uop_seq #(.UOP_MAX(UOP_MAX), .UW(UW)) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .fire (s0_grant),
      .cnt  (cnt0),
      .idx  (uop_idx),
      .last (seq_last),
      .lock (seq_lock)
   );

   issue_pair_rules #(.MEM_CAP(MEM_CAP), .BR_CAP(BR_CAP)) u_rules (
      .cls0     (cls0),
      .cls1     (cls1),
      .s0_single(cnt0 == UW'(1)),
      .s0_last  (seq_last),
      .s1_single(cnt1 == UW'(1)),
      .pair_ok  (pair_ok)
   );

   issue_pipe_map u_map (
      .g0  (s0_grant),
      .g1  (s1_grant),
      .lock(seq_lock),
      .p0  (s0_pipes),
      .p1  (s1_pipes)
   );

   // R1: nothing issues during reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!s0_grant && !s1_grant));

   // R2: younger slot never overtakes the older one
   p_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      s1_grant |-> s0_grant);

   // R3: a paired older micro-op sits in pipe 0 only
   p_pair_pipes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      s1_grant |-> (s0_pipes == PIPE_ZERO && s1_pipes == PIPE_ONE));

   // R4: two single memory accesses never share a cycle
   p_mem_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_grant && s1_grant && cls0 == CL_MEM && cls1 == CL_MEM)
         |-> (cnt0 != UW'(1)));

   // R5: two branches never share a cycle
   p_br_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_grant && cls0 == CL_BRANCH && cls1 == CL_BRANCH) |-> !s1_grant);

   // R6: a locking micro-op issues alone
   p_lock_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_pipes == PIPE_BOTH) |-> !s1_grant);

   // R9: stall keeps the stage quiet and the sequence frozen
   p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (!s0_grant && !s1_grant));
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(uop_idx));

   // R11: a multi-micro-op younger instruction stays put
   p_young_multi_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt1 != UW'(1)) |-> !s1_grant);
endmodule

// File: tb/dual_issue_alloc_test.sv
module dual_issue_alloc_test;
   localparam int CLK_P = 10;
   localparam int NV    = 20;

   typedef struct packed {
      logic       v0, v1;
      logic [1:0] c0, c1, n0, n1;
      logic       b0, b1, st;
      logic       g0, g1;
      logic [1:0] p0, p1, ix;
      logic       r0;
      logic [3:0] req;
   } vec_t;

   // fields: v0 v1 c0 c1 n0 n1 b0 b1 st | g0 g1 p0 p1 ix r0 | req
   localparam vec_t VEC [0:NV-1] = '{
      '{1'b1,1'b1,2'd0,2'd0,2'd1,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd1,2'd2,2'd0,1'b1, 4'd3},  // R3 alu+alu
      '{1'b1,1'b1,2'd1,2'd1,2'd1,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd1,2'd0,2'd0,1'b1, 4'd4},  // R4 mem cap
      '{1'b1,1'b1,2'd2,2'd2,2'd1,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd1,2'd0,2'd0,1'b1, 4'd5},  // R5 branch cap
      '{1'b1,1'b1,2'd1,2'd2,2'd1,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd1,2'd2,2'd0,1'b1, 4'd3},  // R3 mem+branch
      '{1'b1,1'b1,2'd2,2'd1,2'd1,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd1,2'd2,2'd0,1'b1, 4'd3},  // R3 branch+mem
      '{1'b1,1'b1,2'd0,2'd0,2'd2,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd3,2'd0,2'd0,1'b0, 4'd6},  // R6 first
      '{1'b1,1'b1,2'd0,2'd0,2'd2,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd1,2'd2,2'd1,1'b1, 4'd6},  // R6 second
      '{1'b1,1'b1,2'd0,2'd0,2'd3,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd3,2'd0,2'd0,1'b0, 4'd7},  // R7 first
      '{1'b1,1'b1,2'd0,2'd0,2'd3,2'd1,1'b0,1'b0,1'b1, 1'b0,1'b0,2'd0,2'd0,2'd1,1'b0, 4'd9},  // R9 stall mid
      '{1'b1,1'b1,2'd0,2'd0,2'd3,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd3,2'd0,2'd1,1'b0, 4'd7},  // R7 second
      '{1'b1,1'b1,2'd0,2'd0,2'd3,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd1,2'd2,2'd2,1'b1, 4'd7},  // R7 third
      '{1'b1,1'b1,2'd1,2'd1,2'd2,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd3,2'd0,2'd0,1'b0, 4'd8},  // R8 first
      '{1'b1,1'b1,2'd1,2'd1,2'd2,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd1,2'd2,2'd1,1'b1, 4'd8},  // R8 pair
      '{1'b1,1'b1,2'd0,2'd0,2'd1,2'd1,1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd0,2'd0,1'b0, 4'd10}, // R10 block0
      '{1'b1,1'b1,2'd0,2'd0,2'd1,2'd1,1'b0,1'b1,1'b0, 1'b1,1'b0,2'd1,2'd0,2'd0,1'b1, 4'd10}, // R10 block1
      '{1'b1,1'b1,2'd0,2'd0,2'd1,2'd2,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd1,2'd0,2'd0,1'b1, 4'd11}, // R11
      '{1'b0,1'b1,2'd0,2'd0,2'd1,2'd1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd0,2'd0,1'b0, 4'd2},  // R2
      '{1'b1,1'b0,2'd0,2'd0,2'd1,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd1,2'd0,2'd0,1'b1, 4'd12}, // R12
      '{1'b1,1'b1,2'd0,2'd0,2'd0,2'd1,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd1,2'd2,2'd0,1'b1, 4'd13}, // R13
      '{1'b1,1'b1,2'd0,2'd0,2'd1,2'd1,1'b0,1'b0,1'b1, 1'b0,1'b0,2'd0,2'd0,2'd0,1'b0, 4'd9}   // R9 idle stall
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stall = 1'b0;
   logic       s0_valid = 1'b0, s1_valid = 1'b0;
   logic [1:0] s0_class = '0, s1_class = '0;
   logic [1:0] s0_uops = 2'd1, s1_uops = 2'd1;
   logic       s0_block = 1'b0, s1_block = 1'b0;
   logic       s0_grant, s0_retire, s1_grant;
   logic [1:0] s0_pipes, s1_pipes, uop_idx;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dual_issue_alloc uut (
      .clk(clk), .rst_n(rst_n), .stall(stall),
      .s0_valid(s0_valid), .s0_class(s0_class), .s0_uops(s0_uops), .s0_block(s0_block),
      .s1_valid(s1_valid), .s1_class(s1_class), .s1_uops(s1_uops), .s1_block(s1_block),
      .s0_grant(s0_grant), .s0_pipes(s0_pipes), .s0_retire(s0_retire),
      .s1_grant(s1_grant), .s1_pipes(s1_pipes), .uop_idx(uop_idx)
   );

   task automatic check(input int req, input logic [9:0] exp);
      logic [9:0] act;
      act = {s0_grant, s1_grant, s0_pipes, s1_pipes, uop_idx, s0_retire};
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d: {g0,g1,p0,p1,idx,ret} actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      s0_valid = v.v0; s1_valid = v.v1;
      s0_class = v.c0; s1_class = v.c1;
      s0_uops  = v.n0; s1_uops  = v.n1;
      s0_block = v.b0; s1_block = v.b1;
      stall    = v.st;
   endtask

   initial begin
      // R1: valid work offered during reset must not issue
      s0_valid = 1'b1; s1_valid = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk); #1;
      check(1, {1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0});
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i]);
         #1;
         check(int'(VEC[i].req),
               {VEC[i].g0, VEC[i].g1, VEC[i].p0, VEC[i].p1, VEC[i].ix, VEC[i].r0});
      end

      // R1: reset in the middle of a three-micro-op sequence
      @(negedge clk);
      drive('{1'b1,1'b0,2'd0,2'd0,2'd3,2'd1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd0,2'd0,1'b0, 4'd1});
      @(negedge clk); #1;
      check(7, {1'b1, 1'b0, 2'd3, 2'd0, 2'd1, 1'b0});  // R7 index 1 still locks
      rst_n = 1'b0; #1;
      check(1, {1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0});  // R1 index cleared
      @(negedge clk); rst_n = 1'b1; #1;
      check(1, {1'b1, 1'b0, 2'd3, 2'd0, 2'd0, 1'b0});  // R1 restart at micro-op 0

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule